// File: doc/BRIEF.md
# Split-Mode Dual 8-bit PWM Timer

This block is a timer and pulse-width modulation core that works either as a single 16-bit down-counting timer or as two fully independent 8-bit down-counting timers. A mode bit selects between the two. In split operation, each 8-bit half has its own period value, compare value, channel enable and single-slope PWM output. Both halves share one free-running clock prescaler and one run bit.

Software drives the block through a plain synchronous register port. A write is committed on the clock edge where `wr_en` is high. `rd_data` reflects the register selected by `addr` in the same cycle. The port has no data stream, so it has no valid/ready handshake and no back-pressure: every write is accepted. A command register offers a one-cycle hard reset. This reset is meant for switching between the 16-bit and split modes while the timer is stopped.

Register map (addresses on `addr`): 0 control, 1 mode, 2 channel enables, 3 command, 4/5 period low/high, 6/7 compare low/high, 8/9 count low/high (writable), 10 flags.

Top module: `pwm_split_timer`

## Requirements
- R1: MODE bit 0 set selects split operation, in which the low and high bytes run as two unrelated 8-bit timers. With MODE bit 0 clear, {per_hi,per_lo}, {cmp_hi,cmp_lo} and {cnt_hi,cnt_lo} form one 16-bit timer that drives `pwm_lo_o`, and `pwm_hi_o` is held low.
- R2: On every prescaled tick, a counter holding zero loads its period value; otherwise it decrements by one. The counting period is therefore period+1 ticks. In 16-bit mode the low byte borrows from the high byte.
- R3: A PWM output is high while its count is strictly below its compare value. Over one counting period it is high for min(compare, period+1) ticks: compare 0 gives constant low, and compare above the period gives constant high.
- R4: Writes to the period, compare and count registers take effect at the clock edge of the write, even in the middle of a period, with no shadow copy.
- R5: Control bits 3:1 select the tick rate. Codes 0 to 7 divide the clock by 1, 2, 4, 8, 16, 64, 256 and 1024 respectively, using one shared prescaler counter.
- R6: Control bit 0 is the run bit. While it is 0, the counters hold their values and the prescaler is cleared.
- R7: Channel-enable bit 0 gates the low output and bit 1 gates the high output. A disabled output is low.
- R8: Flags bit 0 records an underflow, meaning a tick on which the low 8-bit timer (or the 16-bit timer in 16-bit mode) is at zero. Flags bit 1 records a compare match, meaning a tick on which that count equals its compare value. Writing 1 to a flag bit clears it. The high 8-bit timer sets no flag.
- R9: Writing 3 to command bits 1:0 while the run bit is 0 restores all registers in one cycle. The reset values are: periods 0xFF, compares and counts 0, control, mode, enables and flags 0. The same write while running is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register address |
| wdata | input | 8 | Write data |
| rd_data | output | 8 | Read data of the addressed register |
| pwm_lo_o | output | 1 | PWM output of the low timer (or the 16-bit timer) |
| pwm_hi_o | output | 1 | PWM output of the high timer |

## Verification
A corrupted count or a lost reload shows on the PWM outputs within one counting period: the number of high cycles in a period-long window stops matching min(compare, period+1). A wrong prescaler decode changes how often the readable count moves. This shows up inside a single window of a few divide lengths. Mode, flag and hard-reset faults show up at the read port on the first access after the cycle that triggers them.

// File: rtl/pst_pkg.sv
package pst_pkg;
  localparam int ADDR_W = 4;

  localparam logic [ADDR_W-1:0] A_CTL    = 4'h0;
  localparam logic [ADDR_W-1:0] A_MODE   = 4'h1;
  localparam logic [ADDR_W-1:0] A_CHEN   = 4'h2;
  localparam logic [ADDR_W-1:0] A_CMD    = 4'h3;
  localparam logic [ADDR_W-1:0] A_PER_LO = 4'h4;
  localparam logic [ADDR_W-1:0] A_PER_HI = 4'h5;
  localparam logic [ADDR_W-1:0] A_CMP_LO = 4'h6;
  localparam logic [ADDR_W-1:0] A_CMP_HI = 4'h7;
  localparam logic [ADDR_W-1:0] A_CNT_LO = 4'h8;
  localparam logic [ADDR_W-1:0] A_CNT_HI = 4'h9;
  localparam logic [ADDR_W-1:0] A_FLAGS  = 4'hA;

  localparam logic [1:0] CMD_HARD_RESET = 2'b11;

  // log2 of the division ratio for each select code
  function automatic logic [3:0] div_shift(input logic [2:0] sel);
    case (sel)
      3'd0:    div_shift = 4'd0;
      3'd1:    div_shift = 4'd1;
      3'd2:    div_shift = 4'd2;
      3'd3:    div_shift = 4'd3;
      3'd4:    div_shift = 4'd4;
      3'd5:    div_shift = 4'd6;
      3'd6:    div_shift = 4'd8;
      default: div_shift = 4'd10;
    endcase
  endfunction
endpackage

// File: rtl/pst_prescaler.sv
module pst_prescaler #(
  parameter int PRE_W = 10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       run,
  input  logic [2:0] sel,
  output logic       tick
);
  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] mask;

  always_comb begin
    mask = PRE_W'((32'd1 << pst_pkg::div_shift(sel)) - 32'd1);
    tick = run && ((pre_q & mask) == mask);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          pre_q <= '0;
    else if (clr || !run) pre_q <= '0;
    else                 pre_q <= pre_q + 1'b1;
  end
endmodule

// File: rtl/pst_downcnt.sv
module pst_downcnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         wr,
  input  logic [W-1:0] wr_val,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         dec,
  output logic [W-1:0] cnt
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt <= '0;
    else if (clr)   cnt <= '0;
    else if (wr)    cnt <= wr_val;
    else if (load)  cnt <= load_val;
    else if (dec)   cnt <= cnt - 1'b1;
  end
endmodule

// File: rtl/pst_cmp.sv
module pst_cmp #(
  parameter int W = 8
) (
  input  logic [W-1:0] cnt,
  input  logic [W-1:0] cmp,
  input  logic         en,
  output logic         pwm,
  output logic         match
);
  always_comb begin
    pwm   = en && (cnt < cmp);
    match = (cnt == cmp);
  end
endmodule

// File: rtl/pwm_split_timer.sv
module pwm_split_timer #(
  parameter int HALF_W = 8,
  parameter int PRE_W  = 10
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [pst_pkg::ADDR_W-1:0] addr,
  input  logic [HALF_W-1:0]          wdata,
  output logic [HALF_W-1:0]          rd_data,
  output logic                       pwm_lo_o,
  output logic                       pwm_hi_o
);
  import pst_pkg::*;

  localparam int FULL_W = 2 * HALF_W;
  localparam int NHALF  = 2;

  logic              run_q;
  logic [2:0]        sel_q;
  logic              split_q;
  logic [1:0]        chen_q;
  logic [1:0]        flags_q;
  logic [HALF_W-1:0] per_q [NHALF];
  logic [HALF_W-1:0] cmp_q [NHALF];
  logic [HALF_W-1:0] cnt_q [NHALF];

  logic              tick;
  logic              hard_rst;
  logic [NHALF-1:0]  zero_h;
  logic              zero_full;
  logic [NHALF-1:0]  cnt_wr;
  logic [NHALF-1:0]  pwm8;
  logic [NHALF-1:0]  match8;
  logic              pwm16;
  logic              match16;
  logic              und_ev;
  logic              cmp_ev;
  logic [1:0]        flag_clr;

  assign hard_rst = wr_en && (addr == A_CMD) && (wdata[1:0] == CMD_HARD_RESET) && !run_q;
  assign cnt_wr[0] = wr_en && (addr == A_CNT_LO);
  assign cnt_wr[1] = wr_en && (addr == A_CNT_HI);

  pst_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (hard_rst),
    .run  (run_q),
    .sel  (sel_q),
    .tick (tick)
  );

  assign zero_full = &zero_h;

  genvar gi;
  generate
    for (gi = 0; gi < NHALF; gi++) begin : g_half
      logic h_load;
      logic h_dec;
      assign zero_h[gi] = (cnt_q[gi] == '0);
      if (gi == 0) begin : g_low
        assign h_load = tick && (split_q ? zero_h[0] : zero_full);
        assign h_dec  = tick && !(split_q ? zero_h[0] : zero_full);
      end else begin : g_high
        assign h_load = tick && (split_q ? zero_h[gi] : zero_full);
        assign h_dec  = tick && (split_q ? !zero_h[gi] : (zero_h[0] && !zero_full));
      end

      pst_downcnt #(.W(HALF_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (hard_rst),
        .wr      (cnt_wr[gi]),
        .wr_val  (wdata),
        .load    (h_load),
        .load_val(per_q[gi]),
        .dec     (h_dec),
        .cnt     (cnt_q[gi])
      );

      pst_cmp #(.W(HALF_W)) u_cmp8 (
        .cnt  (cnt_q[gi]),
        .cmp  (cmp_q[gi]),
        .en   (chen_q[gi]),
        .pwm  (pwm8[gi]),
        .match(match8[gi])
      );
    end
  endgenerate

  pst_cmp #(.W(FULL_W)) u_cmp16 (
    .cnt  ({cnt_q[1], cnt_q[0]}),
    .cmp  ({cmp_q[1], cmp_q[0]}),
    .en   (chen_q[0]),
    .pwm  (pwm16),
    .match(match16)
  );

  assign und_ev   = tick && (split_q ? zero_h[0] : zero_full);
  assign cmp_ev   = tick && (split_q ? match8[0] : match16);
  assign flag_clr = (wr_en && (addr == A_FLAGS)) ? wdata[1:0] : 2'b00;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      sel_q   <= '0;
      split_q <= 1'b0;
      chen_q  <= '0;
      flags_q <= '0;
      per_q[0] <= '1;
      per_q[1] <= '1;
      cmp_q[0] <= '0;
      cmp_q[1] <= '0;
    end else if (hard_rst) begin
      run_q   <= 1'b0;
      sel_q   <= '0;
      split_q <= 1'b0;
      chen_q  <= '0;
      flags_q <= '0;
      per_q[0] <= '1;
      per_q[1] <= '1;
      cmp_q[0] <= '0;
      cmp_q[1] <= '0;
    end else begin
      flags_q <= (flags_q & ~flag_clr) | {cmp_ev, und_ev};
      if (wr_en) begin
        case (addr)
          A_CTL:    begin run_q <= wdata[0]; sel_q <= wdata[3:1]; end
          A_MODE:   split_q  <= wdata[0];
          A_CHEN:   chen_q   <= wdata[1:0];
          A_PER_LO: per_q[0] <= wdata;
          A_PER_HI: per_q[1] <= wdata;
          A_CMP_LO: cmp_q[0] <= wdata;
          A_CMP_HI: cmp_q[1] <= wdata;
          default:  ;
        endcase
      end
    end
  end

  always_comb begin
    case (addr)
      A_CTL:    rd_data = HALF_W'({sel_q, run_q});
      A_MODE:   rd_data = HALF_W'(split_q);
      A_CHEN:   rd_data = HALF_W'(chen_q);
      A_PER_LO: rd_data = per_q[0];
      A_PER_HI: rd_data = per_q[1];
      A_CMP_LO: rd_data = cmp_q[0];
      A_CMP_HI: rd_data = cmp_q[1];
      A_CNT_LO: rd_data = cnt_q[0];
      A_CNT_HI: rd_data = cnt_q[1];
      A_FLAGS:  rd_data = HALF_W'(flags_q);
      default:  rd_data = '0;
    endcase
  end

  assign pwm_lo_o = split_q ? pwm8[0] : pwm16;
  assign pwm_hi_o = split_q && pwm8[1];
endmodule

// File: rtl/pst_checker.sv
module pst_checker #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [3:0]   addr,
  input  logic [W-1:0] wdata,
  input  logic         split,
  input  logic         run,
  input  logic [1:0]   chen,
  input  logic         tick,
  input  logic [W-1:0] cnt_lo,
  input  logic [W-1:0] cnt_hi,
  input  logic [W-1:0] per_lo,
  input  logic         pwm_lo,
  input  logic         pwm_hi
);
  a_r1_hi_low_in_16bit: assert property (@(posedge clk) disable iff (!rst_n)
    !split |-> !pwm_hi);

  a_r2_split_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (split && tick && (cnt_lo == '0) && !wr_en) |=> (cnt_lo == $past(per_lo)));

  a_r5_tick_needs_run: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> run);

  a_r6_stopped_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !wr_en) |=> ($stable(cnt_lo) && $stable(cnt_hi)));

  a_r7_lo_gate: assert property (@(posedge clk) disable iff (!rst_n)
    !chen[0] |-> !pwm_lo);

  a_r7_hi_gate: assert property (@(posedge clk) disable iff (!rst_n)
    !chen[1] |-> !pwm_hi);

  a_r9_cmd_ignored_running: assert property (@(posedge clk) disable iff (!rst_n)
    (run && wr_en && (addr == 4'h3) && (wdata[1:0] == 2'b11)) |=> $stable(split));
endmodule

bind pwm_split_timer pst_checker #(.W(HALF_W)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .wr_en  (wr_en),
  .addr   (addr),
  .wdata  (wdata),
  .split  (split_q),
  .run    (run_q),
  .chen   (chen_q),
  .tick   (tick),
  .cnt_lo (cnt_q[0]),
  .cnt_hi (cnt_q[1]),
  .per_lo (per_q[0]),
  .pwm_lo (pwm_lo_o),
  .pwm_hi (pwm_hi_o)
);

// File: tb/pwm_split_timer_bench.sv
`timescale 1ns/1ps
module pwm_split_timer_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [3:0] addr = 4'h0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rd_data;
  logic       pwm_lo_o, pwm_hi_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  pwm_split_timer u_pwm_split_timer (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rd_data(rd_data), .pwm_lo_o(pwm_lo_o), .pwm_hi_o(pwm_hi_o)
  );

  // {per_lo, cmp_lo, per_hi, cmp_hi, expected high count lo, expected high count hi}
  localparam logic [49:0] VEC [6] = '{
    {8'hCF, 8'h68, 8'h44, 8'h11, 9'd104, 9'd17},
    {8'h0F, 8'h00, 8'h07, 8'h08, 9'd0,   9'd8},
    {8'h03, 8'hFF, 8'hFF, 8'h80, 9'd4,   9'd128},
    {8'h00, 8'h01, 8'h00, 8'h00, 9'd1,   9'd0},
    {8'h10, 8'h10, 8'h20, 8'h01, 9'd16,  9'd1},
    {8'hFF, 8'hFF, 8'h01, 8'h01, 9'd255, 9'd1}
  };

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    addr = a;
    #1;
    d = rd_data;
  endtask

  task automatic fresh();
    wr(4'h0, 8'h00);
    wr(4'h3, 8'h03);
  endtask

  // counts changes of the low count over n cycles
  task automatic count_steps(input int n, output int steps);
    logic [7:0] prev, cur;
    steps = 0;
    rd(4'h8, prev);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      rd(4'h8, cur);
      if (cur != prev) steps++;
      prev = cur;
    end
  endtask

  initial begin
    #600000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] d, d2;
    int hl, hh, st;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // reset state (R9 values)
    rd(4'h0, d); chk("R9 reset ctl", d, 0);
    rd(4'h1, d); chk("R9 reset mode", d, 0);
    rd(4'h4, d); chk("R9 reset per_lo", d, 8'hFF);
    rd(4'h5, d); chk("R9 reset per_hi", d, 8'hFF);
    rd(4'hA, d); chk("R9 reset flags", d, 0);
    chk("R7 reset outputs", {pwm_lo_o, pwm_hi_o}, 0);

    // R3 R1 R2 vector table in split mode
    for (int v = 0; v < 6; v++) begin
      logic [7:0] pl, cl, ph, ch;
      {pl, cl, ph, ch} = VEC[v][49:18];
      fresh();
      wr(4'h1, 8'h01);
      wr(4'h2, 8'h03);
      wr(4'h4, pl); wr(4'h5, ph);
      wr(4'h6, cl); wr(4'h7, ch);
      wr(4'h0, 8'h01);
      repeat (4) @(negedge clk);
      hl = 0; hh = 0;
      for (int k = 0; k < 256; k++) begin
        @(negedge clk);
        if (k <= int'(pl) && pwm_lo_o) hl++;
        if (k <= int'(ph) && pwm_hi_o) hh++;
      end
      chk("R3 split low duty", hl, int'(VEC[v][17:9]));
      chk("R3 split high duty", hh, int'(VEC[v][8:0]));
    end

    // R5 prescaler divide ratios
    fresh(); wr(4'h1, 8'h01); wr(4'h4, 8'h03);
    wr(4'h0, 8'h01);           count_steps(64, st);   chk("R5 div1", st, 64);
    wr(4'h0, 8'h00); wr(4'h0, {4'd0, 3'd4, 1'b1}); count_steps(64, st);   chk("R5 div16", st, 4);
    wr(4'h0, 8'h00); wr(4'h0, {4'd0, 3'd5, 1'b1}); count_steps(256, st);  chk("R5 div64", st, 4);
    wr(4'h0, 8'h00); wr(4'h0, {4'd0, 3'd7, 1'b1}); count_steps(2048, st); chk("R5 div1024", st, 2);

    // R6 stopped counter holds
    wr(4'h0, 8'h00);
    rd(4'h8, d); repeat (20) @(negedge clk); rd(4'h8, d2);
    chk("R6 hold while stopped", d2, d);

    // R8 flags
    fresh(); wr(4'h1, 8'h01); wr(4'h4, 8'h03); wr(4'h6, 8'h02);
    wr(4'h0, 8'h01); repeat (10) @(negedge clk); wr(4'h0, 8'h00);
    rd(4'hA, d); chk("R8 both flags set", d, 3);
    wr(4'hA, 8'h01); rd(4'hA, d); chk("R8 clear underflow only", d, 2);
    wr(4'hA, 8'h02); rd(4'hA, d); chk("R8 clear compare", d, 0);

    // R8 high half sets no flag
    fresh(); wr(4'h1, 8'h01); wr(4'h8, 8'hF0);
    wr(4'h5, 8'h02); wr(4'h7, 8'h01);
    wr(4'h0, 8'h01); repeat (40) @(negedge clk); wr(4'h0, 8'h00);
    rd(4'hA, d); chk("R8 no high-half flags", d, 0);

    // R7 channel enable, R4 direct writes
    fresh(); wr(4'h1, 8'h01); wr(4'h4, 8'h0F); wr(4'h6, 8'hFF);
    wr(4'h0, 8'h01); repeat (3) @(negedge clk);
    chk("R7 disabled low output", pwm_lo_o, 0);
    wr(4'h2, 8'h01); chk("R7 enabled low output", pwm_lo_o, 1);
    chk("R7 high output disabled", pwm_hi_o, 0);
    wr(4'h6, 8'h00); chk("R4 compare write immediate low", pwm_lo_o, 0);
    wr(4'h6, 8'hFF); chk("R4 compare write immediate high", pwm_lo_o, 1);
    wr(4'h8, 8'h55); rd(4'h8, d); chk("R4 count write", d, 8'h55);

    // R9 command ignored while running, honoured when stopped
    wr(4'h3, 8'h03);
    rd(4'h1, d); chk("R9 ignored mode", d, 1);
    rd(4'h4, d); chk("R9 ignored per_lo", d, 8'h0F);
    wr(4'h0, 8'h00); wr(4'h3, 8'h03);
    rd(4'h1, d); chk("R9 mode cleared", d, 0);
    rd(4'h4, d); chk("R9 per_lo restored", d, 8'hFF);
    rd(4'h8, d); chk("R9 count cleared", d, 0);
    rd(4'h2, d); chk("R9 enables cleared", d, 0);

    // R1 R2 16-bit mode
    wr(4'h2, 8'h03);
    wr(4'h4, 8'h23); wr(4'h5, 8'h01);
    wr(4'h6, 8'h00); wr(4'h7, 8'h01);
    wr(4'h0, 8'h01);
    repeat (4) @(negedge clk);
    hl = 0; hh = 0;
    for (int k = 0; k < 292; k++) begin
      @(negedge clk);
      if (pwm_lo_o) hl++;
      if (pwm_hi_o) hh++;
    end
    chk("R1 16-bit duty", hl, 256);
    chk("R1 high output idle in 16-bit", hh, 0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule